// File: doc/BRIEF.md
# Serial Port Interrupt and Status Logic

This block sits next to the transmit and receive FIFOs of a synchronous serial port. From the FIFO fill levels, a receive-push strobe, a receive-pop strobe, the shifter's busy signal and a bit-period tick, it builds a five-bit status word and a four-bit raw interrupt word. It also holds the interrupt enable register and the DMA enable register. From those it forms the masked interrupt word, a single interrupt line and one DMA request line for each direction.

Two of the interrupt sources are sticky events. The first is a receive overrun, when a frame arrives while the receive FIFO is full. The second is a receive timeout, when a non-empty receive FIFO has gone unread for a set number of bit periods. Only these two can be cleared, and only by a write of ones to the clear port. The other two sources are live threshold comparisons on the fill levels. They follow the levels from cycle to cycle and cannot be cleared.

Top module: `ssp_irq_status`

## Requirements
- R1: `status_word` is combinational from its inputs. Bit 0 is set when `tx_level` is 0. Bit 1 is set when `tx_level` is not equal to FIFO_DEPTH. Bit 2 is set when `rx_level` is not 0. Bit 3 is set when `rx_level` equals FIFO_DEPTH. Bit 4 copies `shifter_busy`.
- R2: Raw bit 2 is set exactly when `rx_level >= FIFO_DEPTH/2`. Raw bit 3 is set exactly when `tx_level <= FIFO_DEPTH/2`. Both are combinational and follow the levels in the same cycle.
- R3: In a clock cycle where `rx_push` is high and `rx_level` equals FIFO_DEPTH, raw bit 0 (overrun) is set from the next cycle on. It stays set until it is cleared.
- R4: A count of `bit_tick` pulses runs while `rx_level` is non-zero. The count is zeroed in any cycle with `rx_pop` high or with `rx_level` at 0, and a tick in such a cycle is not counted. On the TMO_TICKS-th counted tick (32 by default), raw bit 1 (timeout) is set from the next cycle on and the count restarts. The bit stays set until it is cleared.
- R5: When `clear_we` is high, `clear_wdata` bit 0 clears raw bit 0 and `clear_wdata` bit 1 clears raw bit 1, both from the next cycle. A zero in either position leaves that bit unchanged.
- R6: If a set condition from R3 or R4 and a clear from R5 reach the same raw bit in the same cycle, the bit ends up set.
- R7: `mask_we` loads `mask_wdata` into the interrupt enable register, using bit order 0 overrun, 1 timeout, 2 RX half full, 3 TX half empty. `masked_irq` equals `raw_irq` AND the enable register. `raw_irq` does not depend on the enable register.
- R8: `irq` is high exactly when any bit of `masked_irq` is high.
- R9: `dma_we` loads `dma_wdata` into the DMA enable register. `dma_rx_req` equals enable bit 0 AND raw bit 2. `dma_tx_req` equals enable bit 1 AND raw bit 3.
- R10: After reset the enable register, the DMA enable register, both sticky bits and the timeout count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0 to FIFO_DEPTH |
| rx_level | input | LVL_W | Receive FIFO fill level, 0 to FIFO_DEPTH |
| shifter_busy | input | 1 | Shifter is moving a frame |
| rx_push | input | 1 | A received frame is offered to the receive FIFO |
| rx_pop | input | 1 | The receive FIFO is read |
| bit_tick | input | 1 | One pulse per serial bit period |
| mask_we | input | 1 | Write strobe for the interrupt enable register |
| mask_wdata | input | 4 | New interrupt enable value |
| clear_we | input | 1 | Write strobe for the clear port |
| clear_wdata | input | 2 | Ones clear the matching sticky bits |
| dma_we | input | 1 | Write strobe for the DMA enable register |
| dma_wdata | input | 2 | New DMA enables: bit 0 receive, bit 1 transmit |
| status_word | output | 5 | Status flags |
| raw_irq | output | 4 | Interrupt conditions before masking |
| masked_irq | output | 4 | Interrupt conditions after masking |
| irq | output | 1 | Combined interrupt line |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The level sweeps cover every tx/rx level pair, so an off-by-one threshold shows up as a wrong raw bit 2 or 3 at level 3, 4 or 5. The timeout runs stop at 31 ticks, then pop and start again, so a counter that fires one tick early or late, or that ignores the pop, would set raw bit 1 in the wrong cycle. Same-cycle push-and-clear and tick-and-clear cases would catch a clear that wins over a set, which would drop an overrun. Long random runs mix enable writes with level changes, so a wrong mask or DMA enable bit ordering shows up as a request on the wrong line.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
   // status word positions
   localparam int ST_TX_EMPTY  = 0;
   localparam int ST_TX_NFULL  = 1;
   localparam int ST_RX_NEMPTY = 2;
   localparam int ST_RX_FULL   = 3;
   localparam int ST_BUSY      = 4;
   localparam int ST_W         = 5;
   // interrupt word positions
   localparam int IRQ_OVR      = 0;
   localparam int IRQ_TMO      = 1;
   localparam int IRQ_RXH      = 2;
   localparam int IRQ_TXH      = 3;
   localparam int IRQ_W        = 4;
   // sticky sources occupy the low interrupt bits
   localparam int STICKY_W     = 2;
   // dma enable positions
   localparam int DMA_RX       = 0;
   localparam int DMA_TX       = 1;
   localparam int DMA_W        = 2;
endpackage

// File: rtl/ssp_fifo_flags.sv
module ssp_fifo_flags
   import ssp_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             shifter_busy,
   output logic [ST_W-1:0]  status,
   output logic             rx_half,
   output logic             tx_half,
   output logic             rx_full,
   output logic             rx_nempty
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
   localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(FIFO_DEPTH / 2);

   always_comb begin
      rx_full   = (rx_level == FULL_LVL);
      rx_nempty = (rx_level != '0);
      rx_half   = (rx_level >= HALF_LVL);
      tx_half   = (tx_level <= HALF_LVL);
      status               = '0;
      status[ST_TX_EMPTY]  = (tx_level == '0);
      status[ST_TX_NFULL]  = (tx_level != FULL_LVL);
      status[ST_RX_NEMPTY] = rx_nempty;
      status[ST_RX_FULL]   = rx_full;
      status[ST_BUSY]      = shifter_busy;
   end
endmodule

// File: rtl/ssp_tmo_timer.sv
module ssp_tmo_timer #(
   parameter int TMO_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic rx_pop,
   input  logic bit_tick,
   output logic expire
);
   localparam int               CNT_W = $clog2(TMO_TICKS);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(TMO_TICKS - 1);
   localparam bit               POW2  = ((1 << CNT_W) == TMO_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic             hold_zero;
   logic             count_en;

   assign hold_zero = !armed || rx_pop;
   assign count_en  = bit_tick && !hold_zero;
   assign expire    = count_en && (cnt_q == LAST);

   generate
      if (POW2) begin : g_wrap
         // natural roll-over returns the count to zero after LAST
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (hold_zero) cnt_q <= '0;
            else if (count_en)  cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (hold_zero) cnt_q <= '0;
            else if (count_en)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ssp_sticky_bit.sv
module ssp_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
   import ssp_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  logic [IRQ_W-1:0] mask_wdata,
   input  logic             dma_we,
   input  logic [DMA_W-1:0] dma_wdata,
   input  logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] masked,
   output logic             irq,
   output logic [DMA_W-1:0] dma_req
);
   logic [IRQ_W-1:0] mask_q;
   logic [DMA_W-1:0] dma_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         dma_q  <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         if (dma_we)  dma_q  <= dma_wdata;
      end
   end

   generate
      for (genvar i = 0; i < IRQ_W; i++) begin : g_mask
         assign masked[i] = raw[i] & mask_q[i];
      end
   endgenerate

   assign irq             = |masked;
   assign dma_req[DMA_RX] = dma_q[DMA_RX] & raw[IRQ_RXH];
   assign dma_req[DMA_TX] = dma_q[DMA_TX] & raw[IRQ_TXH];
endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
   import ssp_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int TMO_TICKS  = 32,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LVL_W-1:0]    tx_level,
   input  logic [LVL_W-1:0]    rx_level,
   input  logic                shifter_busy,
   input  logic                rx_push,
   input  logic                rx_pop,
   input  logic                bit_tick,
   input  logic                mask_we,
   input  logic [IRQ_W-1:0]    mask_wdata,
   input  logic                clear_we,
   input  logic [STICKY_W-1:0] clear_wdata,
   input  logic                dma_we,
   input  logic [DMA_W-1:0]    dma_wdata,
   output logic [ST_W-1:0]     status_word,
   output logic [IRQ_W-1:0]    raw_irq,
   output logic [IRQ_W-1:0]    masked_irq,
   output logic                irq,
   output logic                dma_rx_req,
   output logic                dma_tx_req
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (TMO_TICKS < 2) begin : g_bad_tmo
         $error("TMO_TICKS must be at least 2");
      end
      if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl
         $error("LVL_W too narrow for FIFO_DEPTH");
      end
   endgenerate

   logic                rx_half, tx_half, rx_full, rx_nempty;
   logic                tmo_fire;
   logic [STICKY_W-1:0] sticky_set, sticky_clr, sticky_q;
   logic [DMA_W-1:0]    dma_req;

   ssp_fifo_flags #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_flags (
      .tx_level     (tx_level),
      .rx_level     (rx_level),
      .shifter_busy (shifter_busy),
      .status       (status_word),
      .rx_half      (rx_half),
      .tx_half      (tx_half),
      .rx_full      (rx_full),
      .rx_nempty    (rx_nempty)
   );

   ssp_tmo_timer #(
      .TMO_TICKS (TMO_TICKS)
   ) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (rx_nempty),
      .rx_pop   (rx_pop),
      .bit_tick (bit_tick),
      .expire   (tmo_fire)
   );

   always_comb begin
      sticky_set          = '0;
      sticky_set[IRQ_OVR] = rx_push & rx_full;
      sticky_set[IRQ_TMO] = tmo_fire;
      sticky_clr          = clear_we ? clear_wdata : '0;
   end

   generate
      for (genvar i = 0; i < STICKY_W; i++) begin : g_sticky
         ssp_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (sticky_set[i]),
            .clr   (sticky_clr[i]),
            .q     (sticky_q[i])
         );
      end
   endgenerate

   always_comb begin
      raw_irq                 = '0;
      raw_irq[STICKY_W-1:0]   = sticky_q;
      raw_irq[IRQ_RXH]        = rx_half;
      raw_irq[IRQ_TXH]        = tx_half;
   end

   ssp_irq_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (mask_we),
      .mask_wdata (mask_wdata),
      .dma_we     (dma_we),
      .dma_wdata  (dma_wdata),
      .raw        (raw_irq),
      .masked     (masked_irq),
      .irq        (irq),
      .dma_req    (dma_req)
   );

   assign dma_rx_req = dma_req[DMA_RX];
   assign dma_tx_req = dma_req[DMA_TX];
endmodule

// File: rtl/ssp_irq_status_chk.sv
module ssp_irq_status_chk #(
   parameter int FIFO_DEPTH = 8,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             bit_tick,
   input logic             clear_we,
   input logic [1:0]       clear_wdata,
   input logic [3:0]       status_lo,
   input logic [3:0]       raw_irq,
   input logic [3:0]       masked_irq,
   input logic             irq,
   input logic             dma_rx_req,
   input logic             dma_tx_req
);
   logic ovr_cond;
   assign ovr_cond = rx_push && (rx_level == LVL_W'(FIFO_DEPTH));

   p_tx_empty_nfull_r1: assert property (@(posedge clk) disable iff (!rst_n)
      status_lo[0] |-> status_lo[1]);
   p_rx_full_nempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      status_lo[3] |-> status_lo[2]);
   p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_cond |=> raw_irq[0]);
   p_ovr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_irq[0] && !(clear_we && clear_wdata[0])) |=> raw_irq[0]);
   p_ovr_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_irq[0]) |-> $past(ovr_cond));
   p_tmo_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_irq[1]) |-> $past(bit_tick && rx_level != '0 && !rx_pop));
   p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_we && clear_wdata[0] && !ovr_cond) |=> !raw_irq[0]);
   p_tmo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_we && clear_wdata[1] && !bit_tick) |=> !raw_irq[1]);
   p_mask_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_irq & ~raw_irq) == 4'b0000);
   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw_irq != 4'b0000));
   p_dma_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_req |-> raw_irq[2]);
   p_dma_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tx_req |-> raw_irq[3]);
endmodule

bind ssp_irq_status ssp_irq_status_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .LVL_W      (LVL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_level    (rx_level),
   .rx_push     (rx_push),
   .rx_pop      (rx_pop),
   .bit_tick    (bit_tick),
   .clear_we    (clear_we),
   .clear_wdata (clear_wdata),
   .status_lo   (status_word[3:0]),
   .raw_irq     (raw_irq),
   .masked_irq  (masked_irq),
   .irq         (irq),
   .dma_rx_req  (dma_rx_req),
   .dma_tx_req  (dma_tx_req)
);

// File: tb/ssp_irq_status_tb.sv
module ssp_irq_status_tb;
   localparam int D = 8;
   localparam int T = 32;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] tx_level, rx_level;
   logic       shifter_busy, rx_push, rx_pop, bit_tick;
   logic       mask_we, clear_we, dma_we;
   logic [3:0] mask_wdata;
   logic [1:0] clear_wdata, dma_wdata;
   logic [4:0] status_word;
   logic [3:0] raw_irq, masked_irq;
   logic       irq, dma_rx_req, dma_tx_req;

   int n_chk = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;

   // behavioural reference state
   int       m_ovr, m_tmo, m_cnt;
   bit [3:0] m_mask;
   bit [1:0] m_dma;

   always #5 clk = ~clk;

   ssp_irq_status u_dut (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .shifter_busy(shifter_busy), .rx_push(rx_push), .rx_pop(rx_pop),
      .bit_tick(bit_tick), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .clear_we(clear_we), .clear_wdata(clear_wdata), .dma_we(dma_we),
      .dma_wdata(dma_wdata), .status_word(status_word), .raw_irq(raw_irq),
      .masked_irq(masked_irq), .irq(irq), .dma_rx_req(dma_rx_req),
      .dma_tx_req(dma_tx_req)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ovr = 0; m_tmo = 0; m_cnt = 0; m_mask = '0; m_dma = '0;
      end else begin
         int fire;
         int oset;
         fire = 0;
         oset = (rx_push && rx_level == D) ? 1 : 0;
         if (rx_pop || rx_level == 0) m_cnt = 0;
         else if (bit_tick) begin
            if (m_cnt == T - 1) begin m_cnt = 0; fire = 1; end
            else m_cnt = m_cnt + 1;
         end
         if (oset != 0) m_ovr = 1;
         else if (clear_we && clear_wdata[0]) m_ovr = 0;
         if (fire != 0) m_tmo = 1;
         else if (clear_we && clear_wdata[1]) m_tmo = 0;
         if (mask_we) m_mask = mask_wdata;
         if (dma_we)  m_dma  = dma_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_raw();
      logic [3:0] r;
      r[0] = (m_ovr != 0);
      r[1] = (m_tmo != 0);
      r[2] = (rx_level >= D / 2);
      r[3] = (tx_level <= D / 2);
      return r;
   endfunction

   task automatic compare_all();
      logic [4:0] est;
      logic [3:0] er, em;
      est = {shifter_busy, rx_level == D, rx_level != 0, tx_level != D, tx_level == 0};
      er  = exp_raw();
      em  = er & m_mask;
      chk(status_word == est, "R1 status word", 32'(status_word), 32'(est));
      chk(raw_irq[3:2] == er[3:2], "R2 level conditions", 32'(raw_irq[3:2]), 32'(er[3:2]));
      chk(raw_irq[0] == er[0], "R3 overrun", 32'(raw_irq[0]), 32'(er[0]));
      chk(raw_irq[1] == er[1], "R4 timeout", 32'(raw_irq[1]), 32'(er[1]));
      chk(masked_irq == em, "R7 masked word", 32'(masked_irq), 32'(em));
      chk(irq == (em != 0), "R8 irq line", 32'(irq), 32'(em != 0));
      chk(dma_rx_req == (m_dma[0] & er[2]), "R9 rx dma", 32'(dma_rx_req), 32'(m_dma[0] & er[2]));
      chk(dma_tx_req == (m_dma[1] & er[3]), "R9 tx dma", 32'(dma_tx_req), 32'(m_dma[1] & er[3]));
   endtask

   // advance one clock; compare away from the active edge
   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (chk_on) compare_all();
         rx_push = 0; rx_pop = 0; bit_tick = 0;
         mask_we = 0; clear_we = 0; dma_we = 0;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 0; tx_level = 0; rx_level = 4'(D); shifter_busy = 0;
      rx_push = 0; rx_pop = 0; bit_tick = 0; mask_we = 0; mask_wdata = 0;
      clear_we = 0; clear_wdata = 0; dma_we = 0; dma_wdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: enables and sticky bits are zero although both levels qualify
      chk(raw_irq[1:0] == 2'b00, "R10 sticky reset", 32'(raw_irq[1:0]), 0);
      chk(masked_irq == 4'b0000, "R10 mask reset", 32'(masked_irq), 0);
      chk(irq == 1'b0, "R10 irq reset", 32'(irq), 0);
      chk({dma_tx_req, dma_rx_req} == 2'b00, "R10 dma reset", 32'({dma_tx_req, dma_rx_req}), 0);
      chk_on = 1;

      // R1 R2: every level pair, busy toggling
      for (int t = 0; t <= D; t++)
         for (int r = 0; r <= D; r++) begin
            tx_level = 4'(t); rx_level = 4'(r); shifter_busy = ((t + r) % 2) == 1;
            cyc();
         end

      // R7 R8: enable all, then single sources
      mask_we = 1; mask_wdata = 4'hF; cyc();
      tx_level = 4'd6; rx_level = 4'd5; cyc(2);
      mask_we = 1; mask_wdata = 4'b0100; cyc();
      rx_level = 4'd3; cyc();
      chk(irq == 1'b0, "R8 irq low with rx below half", 32'(irq), 0);
      rx_level = 4'd4; cyc();
      chk(irq == 1'b1, "R8 irq high at rx half", 32'(irq), 1);

      // R3: push on a not-full FIFO does not set overrun, push on full does
      rx_level = 4'd7; rx_push = 1; cyc();
      chk(raw_irq[0] == 1'b0, "R3 no overrun below full", 32'(raw_irq[0]), 0);
      rx_level = 4'(D); rx_push = 1; cyc();
      chk(raw_irq[0] == 1'b1, "R3 overrun set", 32'(raw_irq[0]), 1);
      rx_level = 4'd2; cyc(5);
      chk(raw_irq[0] == 1'b1, "R3 overrun sticky", 32'(raw_irq[0]), 1);
      // R5: clearing only timeout leaves overrun
      clear_we = 1; clear_wdata = 2'b10; cyc();
      chk(raw_irq[0] == 1'b1, "R5 other bit kept", 32'(raw_irq[0]), 1);
      clear_we = 1; clear_wdata = 2'b01; cyc();
      chk(raw_irq[0] == 1'b0, "R5 overrun cleared", 32'(raw_irq[0]), 0);
      // R6: push on full with clear in the same cycle
      rx_level = 4'(D); rx_push = 1; clear_we = 1; clear_wdata = 2'b11; cyc();
      chk(raw_irq[0] == 1'b1, "R6 set wins over clear", 32'(raw_irq[0]), 1);
      clear_we = 1; clear_wdata = 2'b01; cyc();
      // R5: level bits not cleared
      rx_level = 4'(D); tx_level = 0; clear_we = 1; clear_wdata = 2'b11; cyc();
      chk(raw_irq[3:2] == 2'b11, "R5 level bits unaffected", 32'(raw_irq[3:2]), 3);

      // R4: 31 ticks, pop, then 32 ticks
      rx_level = 4'd2;
      for (int k = 0; k < T - 1; k++) begin bit_tick = 1; cyc(); cyc(2); end
      chk(raw_irq[1] == 1'b0, "R4 no timeout at 31 ticks", 32'(raw_irq[1]), 0);
      rx_pop = 1; bit_tick = 1; cyc();
      for (int k = 0; k < T - 1; k++) begin bit_tick = 1; cyc(); end
      chk(raw_irq[1] == 1'b0, "R4 pop restarted count", 32'(raw_irq[1]), 0);
      bit_tick = 1; cyc();
      chk(raw_irq[1] == 1'b1, "R4 timeout at 32 ticks", 32'(raw_irq[1]), 1);
      // R6: tick-driven set against clear in the same cycle
      for (int k = 0; k < T - 1; k++) begin bit_tick = 1; cyc(); end
      bit_tick = 1; clear_we = 1; clear_wdata = 2'b10; cyc();
      chk(raw_irq[1] == 1'b1, "R6 timeout set wins", 32'(raw_irq[1]), 1);
      clear_we = 1; clear_wdata = 2'b10; cyc();
      chk(raw_irq[1] == 1'b0, "R5 timeout cleared", 32'(raw_irq[1]), 0);
      // R4: ticks with an empty FIFO never count
      rx_level = 0;
      for (int k = 0; k < 2 * T; k++) begin bit_tick = 1; cyc(); end
      chk(raw_irq[1] == 1'b0, "R4 empty FIFO no timeout", 32'(raw_irq[1]), 0);

      // R9: each enable alone
      dma_we = 1; dma_wdata = 2'b01; rx_level = 4'd6; tx_level = 4'd1; cyc();
      chk({dma_tx_req, dma_rx_req} == 2'b01, "R9 rx only", 32'({dma_tx_req, dma_rx_req}), 1);
      dma_we = 1; dma_wdata = 2'b10; cyc();
      chk({dma_tx_req, dma_rx_req} == 2'b10, "R9 tx only", 32'({dma_tx_req, dma_rx_req}), 2);
      tx_level = 4'd5; cyc();
      chk(dma_tx_req == 1'b0, "R9 tx above half", 32'(dma_tx_req), 0);

      // mixed random traffic, compared every clock
      for (int k = 0; k < 4000; k++) begin
         tx_level     = 4'($urandom_range(0, D));
         rx_level     = ($urandom_range(0, 3) == 0) ? 4'(D) : 4'($urandom_range(0, D));
         shifter_busy = $urandom_range(0, 1) == 1;
         rx_push      = $urandom_range(0, 7) == 0;
         rx_pop       = $urandom_range(0, 40) == 0;
         bit_tick     = $urandom_range(0, 1) == 1;
         if ($urandom_range(0, 30) == 0) begin mask_we = 1; mask_wdata = 4'($urandom); end
         if ($urandom_range(0, 30) == 0) begin dma_we = 1; dma_wdata = 2'($urandom); end
         if ($urandom_range(0, 20) == 0) begin clear_we = 1; clear_wdata = 2'($urandom); end
         cyc();
      end

      finish_run();
   end
endmodule